// File: doc/BRIEF.md
# Serially programmed bank controller

This block sits between a CPU and the external code ROM, tile ROM and save RAM of a cartridge. The CPU programs it one bit at a time by writing to the upper half of its address space (address bit 15 set). Each accepted write either shifts bit 0 of its data into a small accumulator or, when data bit 7 is set, aborts the transfer and forces the upper-fixed code mode. After five accepted bit writes, the assembled value is stored in one of four internal registers. The register is picked by address bits 14:13: 0 is the mode register, 1 is tile register 0, 2 is tile register 1 and 3 is the code register.

From these four registers the block forms, with no added latency, the following outputs:
- two 16 KB code-bank numbers, one for the lower window and one for the upper window;
- two 4 KB tile-bank numbers;
- a two-bit nametable mirroring code;
- an enable and a page select for the save RAM.

A free-running CPU cycle count is an input. It lets the block discard a write that lands too soon after an abort write, which happens when one read-modify-write instruction produces two bus writes in a row.

The loader is a three-state machine:
- SH_EMPTY holds no bits.
- SH_FILL holds from one to three bits.
- SH_LAST holds four bits.

Its transitions are:
- T_FIRST goes from SH_EMPTY to SH_FILL on the first bit.
- T_MORE stays in SH_FILL.
- T_ARM goes from SH_FILL to SH_LAST when the fourth bit is taken.
- T_STORE goes from SH_LAST to SH_EMPTY and writes the register.
- T_ESCAPE goes from any state to SH_EMPTY on an abort write.

A write blocked by the guard causes no transition.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the mode register is 0x1F and the other three registers are 0. The outputs are therefore: code banks 0x00 and 0x0F, tile banks 0x00 and 0x00, mirroring code 3, save RAM enabled, RAM page 0.
- R2: An accepted write with data bit 7 set empties the accumulator and sets mode bits 3:2 to 11, leaving mode bits 4 and 1:0 unchanged.
- R3: An accepted write with data bit 7 clear shifts data bit 0 in, first bit to bit 0. The fifth such write stores the 5-bit value in the register chosen by address bits 14:13 (0 mode, 1 tile 0, 2 tile 1, 3 code). Writes with address bit 15 clear are ignored.
- R4: After an accepted abort write at cycle N, any write whose cycle count is N+1 is ignored. A write at N+2 is accepted.
- R5: The mirroring output equals mode bits 1:0 (0 single screen A, 1 single screen B, 2 vertical, 3 horizontal).
- R6: With mode bits 3:2 equal to 0 or 1, the lower code window takes code bits 3:0 with bit 0 cleared, and the upper window takes that value plus one.
- R7: With mode bits 3:2 equal to 2, the lower code window takes bank 0 and the upper window takes code bits 3:0.
- R8: With mode bits 3:2 equal to 3, the lower code window takes code bits 3:0 and the upper window takes bank 15.
- R9: Bit 4 of both code-bank outputs equals tile register 0 bit 4 in every mode.
- R10: With mode bit 4 set, the tile outputs are tile register 0 and tile register 1. With it clear, they are tile register 0 with bit 0 cleared and with bit 0 set.
- R11: Code register bit 4 set drives the save RAM enable low, unless parameter RAM_GATE_EN is 0, in which case the enable stays high.
- R12: With RAM_TWO_PAGES set, the RAM page is tile register 0 bit 4 when mode bit 4 is set and bit 3 when it is clear. With RAM_TWO_PAGES clear, the page is 0.
- R13: The outputs change right after the clock edge that stores the fifth bit and stay unchanged after the first four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one period per CPU cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per bus write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_cycle | input | CYC_W | Free-running CPU cycle count |
| code_bank_lo | output | REG_W | 16 KB bank for the lower code window |
| code_bank_hi | output | REG_W | 16 KB bank for the upper code window |
| tile_bank_lo | output | REG_W | 4 KB bank for the lower tile window |
| tile_bank_hi | output | REG_W | 4 KB bank for the upper tile window |
| mirror_mode | output | 2 | Nametable mirroring code |
| sram_en | output | 1 | Save RAM access allowed |
| sram_page | output | 1 | 8 KB save RAM page |

## Verification
A table of seven register settings covers the following:
- all four code modes, with and without the outer-bank bit;
- both tile layouts;
- all four mirroring codes;
- the save RAM enable and page.

A wrong bit in any one field therefore moves a distinct output. Directed sequences then use patterns chosen so that each fault gives a different stored value:
- Two bits are left in the shifter before an abort, which shows whether the abort really empties it.
- A write is placed one cycle after an abort and another two cycles after, which shows whether the guard is too short or too long.
- Writes are sent with address bit 15 clear, which shows whether the shifter miscounts.

A variant instance with the RAM options off is checked alongside.

// File: rtl/bank_ctrl_pkg.sv
package bank_ctrl_pkg;

    // Loader states
    typedef enum logic [1:0] {
        SH_EMPTY = 2'd0,
        SH_FILL  = 2'd1,
        SH_LAST  = 2'd2
    } loader_state_e;

    // Register selection by address bits 14:13
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = 2;
    localparam int REG_MODE  = 0;
    localparam int REG_TILE0 = 1;
    localparam int REG_TILE1 = 2;
    localparam int REG_CODE  = 3;

    // Code window modes (mode register bits 3:2)
    localparam logic [1:0] CM_PAIR_A   = 2'd0;
    localparam logic [1:0] CM_PAIR_B   = 2'd1;
    localparam logic [1:0] CM_FIX_LOW  = 2'd2;
    localparam logic [1:0] CM_FIX_HIGH = 2'd3;

    // Mirroring codes
    localparam logic [1:0] MIR_SINGLE_A = 2'd0;
    localparam logic [1:0] MIR_SINGLE_B = 2'd1;
    localparam logic [1:0] MIR_VERT     = 2'd2;
    localparam logic [1:0] MIR_HORIZ    = 2'd3;

endpackage

// File: rtl/shift_loader.sv
module shift_loader
    import bank_ctrl_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter int CYC_W     = 16,
    parameter int GUARD_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic                 map_hit_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [7:0]           wdata_i,
    input  logic [CYC_W-1:0]     cycle_i,
    output logic                 commit_o,
    output logic [SEL_W-1:0]     commit_sel_o,
    output logic [REG_W-1:0]     commit_val_o,
    output logic                 esc_o
);

    localparam int ACC_W = REG_W - 1;
    localparam int CNT_W = $clog2(REG_W);
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(REG_W - 2);
    localparam logic [CYC_W-1:0] GUARD_LIM = CYC_W'(GUARD_CYC);

    loader_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ACC_W-1:0] acc_q, acc_d;

    // Guard window after an accepted abort write
    logic             guard_armed_q;
    logic [CYC_W-1:0] esc_cyc_q;
    logic [CYC_W-1:0] since_esc;
    logic             blocked;
    logic             take, esc_take, bit_take;

    logic unused_data_bits;
    assign unused_data_bits = ^wdata_i[6:1];

    assign since_esc = cycle_i - esc_cyc_q;
    assign blocked   = guard_armed_q && (since_esc < GUARD_LIM);
    assign take      = wr_i && map_hit_i && !blocked;
    assign esc_take  = take && wdata_i[7];
    assign bit_take  = take && !wdata_i[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_armed_q <= 1'b0;
            esc_cyc_q     <= '0;
        end else if (esc_take) begin
            guard_armed_q <= 1'b1;
            esc_cyc_q     <= cycle_i;
        end else if (guard_armed_q && !blocked) begin
            guard_armed_q <= 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_EMPTY;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            acc_q   <= acc_d;
        end
    end

    // Next state: T_FIRST, T_MORE, T_ARM, T_STORE, T_ESCAPE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_d   = acc_q;
        if (esc_take) begin
            state_d = SH_EMPTY;
            cnt_d   = '0;
            acc_d   = '0;
        end else if (bit_take) begin
            unique case (state_q)
                SH_EMPTY, SH_FILL: begin
                    acc_d[cnt_q] = wdata_i[0];
                    cnt_d        = cnt_q + 1'b1;
                    state_d      = (cnt_q == LAST_IDX) ? SH_LAST : SH_FILL;
                end
                SH_LAST: begin
                    state_d = SH_EMPTY;
                    cnt_d   = '0;
                    acc_d   = '0;
                end
                default: begin
                    state_d = SH_EMPTY;
                    cnt_d   = '0;
                    acc_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit_o     = bit_take && (state_q == SH_LAST);
        commit_sel_o = sel_i;
        commit_val_o = {wdata_i[0], acc_q};
        esc_o        = esc_take;
    end

    // R2
    escape_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_take |=> (state_q == SH_EMPTY) && (cnt_q == '0));

    // R4
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && map_hit_i && blocked) |=> ($stable(state_q) && $stable(cnt_q) && $stable(acc_q)));

    // R3
    commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (cnt_q == CNT_W'(REG_W - 1)));

endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
    import bank_ctrl_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [SEL_W-1:0]  commit_sel_i,
    input  logic [REG_W-1:0]  commit_val_i,
    input  logic              esc_i,
    output logic [REG_W-1:0]  mode_o,
    output logic [REG_W-1:0]  tile0_o,
    output logic [REG_W-1:0]  tile1_o,
    output logic [REG_W-1:0]  code_o
);

    logic [REG_W-1:0] regs_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= (i == REG_MODE) ? '1 : '0;
            end
        end else if (commit_i) begin
            regs_q[commit_sel_i] <= commit_val_i;
        end else if (esc_i) begin
            regs_q[REG_MODE][3:2] <= 2'b11;
        end
    end

    assign mode_o  = regs_q[REG_MODE];
    assign tile0_o = regs_q[REG_TILE0];
    assign tile1_o = regs_q[REG_TILE1];
    assign code_o  = regs_q[REG_CODE];

    // R2
    escape_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_i && !commit_i) |=> (mode_o[3:2] == 2'b11) && (mode_o[1:0] == $past(mode_o[1:0]))
                                  && (mode_o[4] == $past(mode_o[4])));

    // R3
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (regs_q[$past(commit_sel_i)] == $past(commit_val_i)));

endmodule

// File: rtl/code_bank_map.sv
module code_bank_map
    import bank_ctrl_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [1:0]       mode_i,
    input  logic [REG_W-2:0] base_i,
    input  logic             outer_i,
    output logic [REG_W-1:0] lo_o,
    output logic [REG_W-1:0] hi_o
);

    localparam int BASE_W = REG_W - 1;

    always_comb begin
        unique case (mode_i)
            CM_PAIR_A, CM_PAIR_B: begin
                lo_o = {outer_i, base_i & ~BASE_W'(1)};
                hi_o = {outer_i, base_i |  BASE_W'(1)};
            end
            CM_FIX_LOW: begin
                lo_o = {outer_i, {BASE_W{1'b0}}};
                hi_o = {outer_i, base_i};
            end
            default: begin
                lo_o = {outer_i, base_i};
                hi_o = {outer_i, {BASE_W{1'b1}}};
            end
        endcase
    end

endmodule

// File: rtl/tile_ram_map.sv
module tile_ram_map #(
    parameter int REG_W         = 5,
    parameter bit RAM_GATE_EN   = 1'b1,
    parameter bit RAM_TWO_PAGES = 1'b1
) (
    input  logic             split_i,
    input  logic [REG_W-1:0] tile0_i,
    input  logic [REG_W-1:0] tile1_i,
    input  logic             ram_off_i,
    output logic [REG_W-1:0] tile_lo_o,
    output logic [REG_W-1:0] tile_hi_o,
    output logic             sram_en_o,
    output logic             sram_page_o
);

    always_comb begin
        if (split_i) begin
            tile_lo_o = tile0_i;
            tile_hi_o = tile1_i;
        end else begin
            tile_lo_o = {tile0_i[REG_W-1:1], 1'b0};
            tile_hi_o = {tile0_i[REG_W-1:1], 1'b1};
        end
    end

    generate
        if (RAM_GATE_EN) begin : g_gate
            assign sram_en_o = !ram_off_i;
        end else begin : g_nogate
            logic unused_ram_off;
            assign unused_ram_off = ram_off_i;
            assign sram_en_o      = 1'b1;
        end

        if (RAM_TWO_PAGES) begin : g_two
            assign sram_page_o = split_i ? tile0_i[REG_W-1] : tile0_i[REG_W-2];
        end else begin : g_one
            assign sram_page_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
    import bank_ctrl_pkg::*;
#(
    parameter int REG_W         = 5,
    parameter int CYC_W         = 16,
    parameter int GUARD_CYC     = 2,
    parameter bit RAM_GATE_EN   = 1'b1,
    parameter bit RAM_TWO_PAGES = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_wdata,
    input  logic [CYC_W-1:0] cpu_cycle,
    output logic [REG_W-1:0] code_bank_lo,
    output logic [REG_W-1:0] code_bank_hi,
    output logic [REG_W-1:0] tile_bank_lo,
    output logic [REG_W-1:0] tile_bank_hi,
    output logic [1:0]       mirror_mode,
    output logic             sram_en,
    output logic             sram_page
);

    logic             commit;
    logic [SEL_W-1:0] commit_sel;
    logic [REG_W-1:0] commit_val;
    logic             esc;
    logic [REG_W-1:0] mode_q, tile0_q, tile1_q, code_q;

    logic unused_addr_bits;
    assign unused_addr_bits = ^cpu_addr[12:0];

    shift_loader #(
        .REG_W     (REG_W),
        .CYC_W     (CYC_W),
        .GUARD_CYC (GUARD_CYC)
    ) u_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (cpu_we),
        .map_hit_i    (cpu_addr[15]),
        .sel_i        (cpu_addr[14:13]),
        .wdata_i      (cpu_wdata),
        .cycle_i      (cpu_cycle),
        .commit_o     (commit),
        .commit_sel_o (commit_sel),
        .commit_val_o (commit_val),
        .esc_o        (esc)
    );

    bank_reg_file #(.REG_W(REG_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .commit_sel_i (commit_sel),
        .commit_val_i (commit_val),
        .esc_i        (esc),
        .mode_o       (mode_q),
        .tile0_o      (tile0_q),
        .tile1_o      (tile1_q),
        .code_o       (code_q)
    );

    code_bank_map #(.REG_W(REG_W)) u_code (
        .mode_i  (mode_q[3:2]),
        .base_i  (code_q[REG_W-2:0]),
        .outer_i (tile0_q[REG_W-1]),
        .lo_o    (code_bank_lo),
        .hi_o    (code_bank_hi)
    );

    tile_ram_map #(
        .REG_W         (REG_W),
        .RAM_GATE_EN   (RAM_GATE_EN),
        .RAM_TWO_PAGES (RAM_TWO_PAGES)
    ) u_tile (
        .split_i     (mode_q[4]),
        .tile0_i     (tile0_q),
        .tile1_i     (tile1_q),
        .ram_off_i   (code_q[REG_W-1]),
        .tile_lo_o   (tile_bank_lo),
        .tile_hi_o   (tile_bank_hi),
        .sram_en_o   (sram_en),
        .sram_page_o (sram_page)
    );

    assign mirror_mode = mode_q[1:0];

    // R6
    paired_windows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3] == 1'b0) |-> (code_bank_hi == code_bank_lo + 1'b1));

    // R8
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3:2] == CM_FIX_HIGH) |-> (code_bank_hi[REG_W-2:0] == '1));

    // R9
    outer_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_bank_lo[REG_W-1] == tile0_q[REG_W-1]) && (code_bank_hi[REG_W-1] == tile0_q[REG_W-1]));

    // R10
    tile_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[4] |-> (!tile_bank_lo[0] && (tile_bank_hi == (tile_bank_lo | 1'b1))));

endmodule

// File: tb/serial_bank_ctrl_tb.sv
module serial_bank_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] cpu_cycle = '0;

    logic [4:0] code_lo, code_hi, tile_lo, tile_hi;
    logic [1:0] mirror;
    logic       sram_en, sram_page;
    logic [4:0] v_code_lo, v_code_hi, v_tile_lo, v_tile_hi;
    logic [1:0] v_mirror;
    logic       v_sram_en, v_sram_page;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cpu_cycle <= cpu_cycle + 16'd1;

    serial_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_cycle(cpu_cycle),
        .code_bank_lo(code_lo), .code_bank_hi(code_hi),
        .tile_bank_lo(tile_lo), .tile_bank_hi(tile_hi),
        .mirror_mode(mirror), .sram_en(sram_en), .sram_page(sram_page)
    );

    serial_bank_ctrl #(.RAM_GATE_EN(1'b0), .RAM_TWO_PAGES(1'b0)) u_var (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_cycle(cpu_cycle),
        .code_bank_lo(v_code_lo), .code_bank_hi(v_code_hi),
        .tile_bank_lo(v_tile_lo), .tile_bank_hi(v_tile_hi),
        .mirror_mode(v_mirror), .sram_en(v_sram_en), .sram_page(v_sram_page)
    );

    // {mode, tile0, tile1, code, exp code_lo, code_hi, tile_lo, tile_hi, mirror, sram_en, page}
    localparam logic [43:0] VEC [7] = '{
        {5'h0C, 5'h00, 5'h00, 5'h05, 5'h05, 5'h0F, 5'h00, 5'h01, 2'd0, 1'b1, 1'b0},
        {5'h09, 5'h06, 5'h03, 5'h07, 5'h00, 5'h07, 5'h06, 5'h07, 2'd1, 1'b1, 1'b0},
        {5'h06, 5'h0B, 5'h02, 5'h09, 5'h08, 5'h09, 5'h0A, 5'h0B, 2'd2, 1'b1, 1'b1},
        {5'h13, 5'h15, 5'h0E, 5'h03, 5'h12, 5'h13, 5'h15, 5'h0E, 2'd3, 1'b1, 1'b1},
        {5'h1C, 5'h10, 5'h1F, 5'h02, 5'h12, 5'h1F, 5'h10, 5'h1F, 2'd0, 1'b1, 1'b1},
        {5'h0A, 5'h11, 5'h00, 5'h0F, 5'h10, 5'h1F, 5'h10, 5'h11, 2'd2, 1'b1, 1'b0},
        {5'h0E, 5'h01, 5'h04, 5'h1A, 5'h0A, 5'h0F, 5'h00, 5'h01, 2'd2, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [4:0] v);
        for (int b = 0; b < 5; b++) cpu_write(a, {7'd0, v[b]});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 code_lo", code_lo, 5'h00);
        check("R1 code_hi", code_hi, 5'h0F);
        check("R1 tile_lo", tile_lo, 5'h00);
        check("R1 tile_hi", tile_hi, 5'h00);
        check("R1 mirror", mirror, 2'd3);
        check("R1 sram_en", sram_en, 1'b1);
        check("R1 sram_page", sram_page, 1'b0);

        // Table walk: R3 R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < 7; i++) begin
            logic [43:0] v;
            v = VEC[i];
            write_reg(16'h8000, v[43:39]);
            write_reg(16'hA000, v[38:34]);
            write_reg(16'hC000, v[33:29]);
            write_reg(16'hE000, v[28:24]);
            check($sformatf("R6/R7/R8/R9 vec%0d code_lo", i), code_lo, v[23:19]);
            check($sformatf("R6/R7/R8/R9 vec%0d code_hi", i), code_hi, v[18:14]);
            check($sformatf("R10 vec%0d tile_lo", i), tile_lo, v[13:9]);
            check($sformatf("R10 vec%0d tile_hi", i), tile_hi, v[8:4]);
            check($sformatf("R5 vec%0d mirror", i), mirror, v[3:2]);
            check($sformatf("R11 vec%0d sram_en", i), sram_en, v[1]);
            check($sformatf("R12 vec%0d sram_page", i), sram_page, v[0]);
            check($sformatf("R11 vec%0d variant sram_en", i), v_sram_en, 1'b1);
            check($sformatf("R12 vec%0d variant page", i), v_sram_page, 1'b0);
            check($sformatf("R3 vec%0d variant code_lo", i), v_code_lo, v[23:19]);
        end

        // R2: abort write with two bits pending
        write_reg(16'h8000, 5'h00);
        write_reg(16'hA000, 5'h00);
        write_reg(16'hE000, 5'h04);
        check("R6 pair lo", code_lo, 5'h04);
        check("R6 pair hi", code_hi, 5'h05);
        cpu_write(16'hE000, 8'h01);
        cpu_write(16'hE000, 8'h01);
        cpu_write(16'hE000, 8'h80);
        check("R2 abort keeps lo", code_lo, 5'h04);
        check("R2 abort forces hi", code_hi, 5'h0F);
        check("R2 abort keeps mirror", mirror, 2'd0);
        idle(2);
        write_reg(16'hE000, 5'h06);
        check("R2 shifter emptied", code_lo, 5'h06);

        // R4: write one cycle after abort is dropped, two cycles after is taken
        cpu_write(16'hE000, 8'h80);
        cpu_write(16'hE000, 8'h01);
        write_reg(16'hE000, 5'h03);
        check("R4 guard window", code_lo, 5'h03);
        check("R4 mode after abort", code_hi, 5'h0F);

        // R3/R13: low-half writes ignored; no change before fifth bit
        cpu_write(16'h6000, 8'h01);
        cpu_write(16'h6000, 8'h01);
        cpu_write(16'h6000, 8'h01);
        check("R3 low-half writes ignored", code_lo, 5'h03);
        cpu_write(16'hE000, 8'h01);
        cpu_write(16'hE000, 8'h00);
        cpu_write(16'hE000, 8'h01);
        cpu_write(16'hE000, 8'h00);
        check("R13 unchanged after four bits", code_lo, 5'h03);
        cpu_write(16'hE000, 8'h00);
        check("R13 updated after fifth bit", code_lo, 5'h05);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule